// File: doc/BRIEF.md
# CRC Frame Serial Transmitter

This block takes a 7-bit message from a parallel port and sends it as one serial frame on a single output line. The frame carries a start bit, the message, a 3-bit CRC, an even parity bit and a stop bit. When a message is accepted, a bit-serial divider computes its CRC with the generator x^3 + x + 1. The divider takes one message bit per clock. A fixed 8-clock division window must close before the frame may start. The line then shifts out one bit on each cycle in which the bit enable is high.

After reset the line sends a fixed run of idle (high) bits before any frame, so that a receiver can settle. A load strobe is accepted only while the block reports itself not busy. A single-cycle done pulse marks the end of each frame. The bit enable sets the line rate and comes from elsewhere. The division itself always runs at the full clock rate.

Top module: `crc_frame_tx`

## Requirements
- R1: A synchronous reset (rst_n sampled low at a clock edge) puts the block into the preamble phase: tx = 1, busy = 1, done = 0.
- R2: After reset, tx stays 1 and busy stays 1 for exactly 11 enabled bit periods. busy drops after the edge that samples the 11th bit enable. A load during this phase is ignored: no frame follows it.
- R3: A load sampled while busy = 0 is accepted: busy is 1 after that edge. tx then stays 1 for exactly 8 clocks, whatever the bit enable does, while the division settles.
- R4: The CRC field is the remainder of (message · x^3) divided by x^3 + x + 1 (generator 1011), with the message MSB as the highest term. Example: message 0x40 gives 100, 0x01 gives 011, 0x55 gives 001.
- R5: The frame is 13 bits in this order: start bit 0, data[6] down to data[0], crc[2] down to crc[0], parity, stop bit 1. The first bit appears after the first enabled edge that follows the 8 division clocks. Each later bit appears after the next enabled edge, and tx never changes on an edge where the bit enable is low.
- R6: The parity bit makes the number of ones among the 7 data bits, the 3 CRC bits and the parity bit even.
- R7: A load sampled while busy = 1 is ignored. The frame in flight is unchanged, and no further frame is sent afterwards.
- R8: done is 1 for exactly one clock, after the enabled edge that ends the stop bit's period. busy is 0 on the following clock.
- R9: tx is 1 whenever busy is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bit_en | input | 1 | Bit-rate enable; one tx bit per high cycle |
| data_in | input | 7 | Message to send, captured on an accepted load |
| load | input | 1 | Load strobe for data_in |
| busy | output | 1 | High during preamble, division, sending and the done cycle |
| done | output | 1 | One-clock pulse at the end of a frame |
| tx | output | 1 | Serial line, idles high |

## Verification
busy is due one edge after an accepted load. tx must hold high through the next 8 edges. Each frame bit is due one edge after the enable that releases it, and done is due one edge after the 14th enabled edge in the sending phase. The bench drives every input just after a falling edge, lets exactly one rising edge pass, and samples 1 ns later. Each expected value is therefore tied to a known edge count, both with the enable high every cycle and with the enable high one cycle in three. Loads given during the preamble and in mid-frame are followed by idle cycles in which the line must stay high and busy must stay low.

// File: rtl/crc_tx_pkg.sv
// Package: shared state encoding for the CRC frame transmitter.
// Assumes: one controller instance per transmitter.
package crc_tx_pkg;

    typedef enum logic [2:0] {
        ST_PREAMBLE = 3'd0,
        ST_WAIT     = 3'd1,
        ST_DIVIDE   = 3'd2,
        ST_SEND     = 3'd3,
        ST_DONE     = 3'd4
    } tx_state_e;

endpackage

// File: rtl/crc_tx_ctrl.sv
// Module: crc_tx_ctrl
// Sequencing FSM. It runs the idle preamble, waits for a load, holds
// through the division window and the frame, then gives the done cycle.
// Assumes: settled and finished come from the divider and framer, and
// each lasts no longer than its phase.
module crc_tx_ctrl
    import crc_tx_pkg::*;
#(
    parameter int PRE_LEN = 11
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bit_en,
    input  logic load,
    input  logic settled,
    input  logic finished,
    output logic accept,
    output logic dividing,
    output logic load_frame,
    output logic sending,
    output logic busy,
    output logic done
);

    localparam int PCNT_W = (PRE_LEN > 1) ? $clog2(PRE_LEN) : 1;
    localparam logic [PCNT_W-1:0] PRE_LAST = PCNT_W'(PRE_LEN - 1);

    tx_state_e         state_q, state_d;
    logic [PCNT_W-1:0] pcnt_q;
    logic              pre_last;

    assign pre_last = (pcnt_q == PRE_LAST);

    // Next-state selection.
    always_comb begin
        state_d = state_q;
        case (state_q)
            ST_PREAMBLE: if (bit_en && pre_last) state_d = ST_WAIT;
            ST_WAIT:     if (load)               state_d = ST_DIVIDE;
            ST_DIVIDE:   if (settled)            state_d = ST_SEND;
            ST_SEND:     if (finished)           state_d = ST_DONE;
            ST_DONE:                             state_d = ST_WAIT;
            default:                             state_d = ST_PREAMBLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_PREAMBLE;
        else        state_q <= state_d;
    end

    // Preamble counter: counts the enabled idle bit periods.
    always_ff @(posedge clk) begin
        if (!rst_n)
            pcnt_q <= '0;
        else if (state_q == ST_PREAMBLE && bit_en && !pre_last)
            pcnt_q <= pcnt_q + 1'b1;
    end

    assign accept     = (state_q == ST_WAIT) && load;
    assign dividing   = (state_q == ST_DIVIDE);
    assign load_frame = dividing && settled;
    assign sending    = (state_q == ST_SEND);
    assign busy       = (state_q != ST_WAIT);
    assign done       = (state_q == ST_DONE);

endmodule

// File: rtl/crc_tx_divider.sv
// Module: crc_tx_divider
// Bit-serial CRC divider. The message is fed MSB first into a feedback
// shift register that needs no appended zeros. The settle counter flags
// the remainder as final once MSG_W+1 clocks have passed since start.
// Assumes: run stays high until settled is seen; start and run are never
// high together.
module crc_tx_divider #(
    parameter int MSG_W = 7,
    parameter int CRC_W = 3,
    parameter logic [CRC_W-1:0] POLY = 3'b011
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             run,
    input  logic [MSG_W-1:0] data_in,
    output logic [MSG_W-1:0] data_q,
    output logic [CRC_W-1:0] crc_q,
    output logic             settled
);

    localparam int CNT_W = $clog2(MSG_W + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(MSG_W);

    logic [MSG_W-1:0] msg_q;
    logic [CNT_W-1:0] cnt_q;
    logic [CRC_W-1:0] crc_d;
    logic             fb;

    // One division step: feedback = remainder MSB xor next message bit.
    always_comb begin
        fb    = crc_q[CRC_W-1] ^ msg_q[MSG_W-1];
        crc_d = {crc_q[CRC_W-2:0], 1'b0} ^ (fb ? POLY : '0);
    end

    // Message capture, remainder update and settle count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            msg_q  <= '0;
            data_q <= '0;
            crc_q  <= '0;
            cnt_q  <= '0;
        end else if (start) begin
            msg_q  <= data_in;
            data_q <= data_in;
            crc_q  <= '0;
            cnt_q  <= '0;
        end else if (run && cnt_q != LAST) begin
            crc_q  <= crc_d;
            msg_q  <= {msg_q[MSG_W-2:0], 1'b0};
            cnt_q  <= cnt_q + 1'b1;
        end
    end

    assign settled = run && (cnt_q == LAST);

endmodule

// File: rtl/crc_tx_framer.sv
// Module: crc_tx_framer
// Frame builder and line shifter. It assembles start, data, CRC, even
// parity and stop bits, then releases one bit per enabled cycle.
// Assumes: load_frame and active are never high together.
module crc_tx_framer #(
    parameter int MSG_W = 7,
    parameter int CRC_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_frame,
    input  logic             active,
    input  logic             bit_en,
    input  logic [MSG_W-1:0] data_q,
    input  logic [CRC_W-1:0] crc_q,
    output logic             tx,
    output logic             finished
);

    localparam int FRAME_W = MSG_W + CRC_W + 3;
    localparam int SENT_W  = $clog2(FRAME_W + 1);
    localparam logic [SENT_W-1:0] LAST = SENT_W'(FRAME_W);

    logic [FRAME_W-1:0] fr_q;
    logic [SENT_W-1:0]  sent_q;
    logic               parity;

    assign parity = ^{data_q, crc_q};

    // Frame load and bit shifting onto the line.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fr_q   <= '0;
            sent_q <= '0;
            tx     <= 1'b1;
        end else if (load_frame) begin
            fr_q   <= {1'b0, data_q, crc_q, parity, 1'b1};
            sent_q <= '0;
        end else if (active && bit_en && sent_q != LAST) begin
            tx     <= fr_q[FRAME_W-1];
            fr_q   <= {fr_q[FRAME_W-2:0], 1'b1};
            sent_q <= sent_q + 1'b1;
        end
    end

    assign finished = active && bit_en && (sent_q == LAST);

endmodule

// File: rtl/crc_frame_tx.sv
// Module: crc_frame_tx (top)
// Serial transmitter for CRC-protected frames with a power-up preamble.
// Assumes: bit_en is a single-cycle pulse train at the line rate.
module crc_frame_tx #(
    parameter int MSG_W   = 7,
    parameter int CRC_W   = 3,
    parameter logic [CRC_W-1:0] POLY = 3'b011,
    parameter int PRE_LEN = 11
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bit_en,
    input  logic [MSG_W-1:0] data_in,
    input  logic             load,
    output logic             busy,
    output logic             done,
    output logic             tx
);

    logic             accept, dividing, load_frame, sending;
    logic             settled, finished;
    logic [MSG_W-1:0] data_q;
    logic [CRC_W-1:0] crc_q;

    crc_tx_ctrl #(.PRE_LEN(PRE_LEN)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .load(load),
        .settled(settled), .finished(finished), .accept(accept),
        .dividing(dividing), .load_frame(load_frame), .sending(sending),
        .busy(busy), .done(done)
    );

    crc_tx_divider #(.MSG_W(MSG_W), .CRC_W(CRC_W), .POLY(POLY)) u_div (
        .clk(clk), .rst_n(rst_n), .start(accept), .run(dividing),
        .data_in(data_in), .data_q(data_q), .crc_q(crc_q), .settled(settled)
    );

    crc_tx_framer #(.MSG_W(MSG_W), .CRC_W(CRC_W)) u_frm (
        .clk(clk), .rst_n(rst_n), .load_frame(load_frame), .active(sending),
        .bit_en(bit_en), .data_q(data_q), .crc_q(crc_q), .tx(tx),
        .finished(finished)
    );

endmodule

// File: rtl/crc_frame_tx_chk.sv
// Module: crc_frame_tx_chk
// Port-level protocol checks, bound onto every crc_frame_tx instance.
module crc_frame_tx_chk (
    input logic clk,
    input logic rst_n,
    input logic bit_en,
    input logic load,
    input logic busy,
    input logic done,
    input logic tx
);

    // R8
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R8
    done_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !busy);

    // R9
    idle_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> tx);

    // R3
    load_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && load) |=> (busy && tx));

    // R5
    tx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bit_en |=> $stable(tx));

endmodule

bind crc_frame_tx crc_frame_tx_chk u_chk (
    .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .load(load),
    .busy(busy), .done(done), .tx(tx)
);

// File: tb/sim_crc_frame_tx.sv
module sim_crc_frame_tx;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bit_en = 1'b0;
    logic       load = 1'b0;
    logic [6:0] data_in = '0;
    logic       busy, done, tx;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    crc_frame_tx u0 (
        .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .data_in(data_in),
        .load(load), .busy(busy), .done(done), .tx(tx)
    );

    // Stimulus table: {message, expected CRC}
    localparam logic [9:0] VEC [6] = '{
        {7'h00, 3'b000}, {7'h40, 3'b100}, {7'h01, 3'b011},
        {7'h7F, 3'b000}, {7'h55, 3'b001}, {7'h2A, 3'b001}
    };

    function automatic logic [2:0] model_crc(input logic [6:0] d);
        logic [9:0] r;
        r = {d, 3'b000};
        for (int i = 9; i >= 3; i--)
            if (r[i]) r[i -: 4] = r[i -: 4] ^ 4'b1011;
        return r[2:0];
    endfunction

    task automatic check(input int act, input int exp, input string what);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", what, act, exp);
        end
    endtask

    // Drive inputs after a falling edge, pass one rising edge, sample 1 ns later.
    task automatic tick(input logic en, input logic ld, input logic [6:0] d);
        @(negedge clk);
        bit_en  = en;
        load    = ld;
        data_in = d;
        @(posedge clk);
        #1;
    endtask

    task automatic send_frame(input logic [6:0] d, input logic [2:0] c, input int gap);
        logic [12:0] f;
        f = {1'b0, d, c, ^{d, c}, 1'b1};
        tick(1'b1, 1'b1, d);
        check(busy, 1, "R3 busy after accepted load");
        for (int k = 0; k < 8; k++) begin
            tick(gap == 0, 1'b0, 7'h00);
            check(tx, 1, "R3 tx held high during division");
        end
        for (int b = 0; b < 13; b++) begin
            tick(1'b1, b == 5, ~d);
            if (b >= 8 && b <= 10)      check(tx, f[12-b], "R4 crc bit");
            else if (b == 11)           check(tx, f[12-b], "R6 parity bit");
            else if (b == 5)            check(tx, f[12-b], "R7 data bit after busy load");
            else                        check(tx, f[12-b], "R5 frame bit");
            check(done, 0, "R8 no done mid-frame");
            for (int g = 0; g < gap; g++) begin
                tick(1'b0, 1'b0, 7'h00);
                check(tx, f[12-b], "R5 tx stable without enable");
            end
        end
        tick(1'b1, 1'b0, 7'h00);
        check(done, 1, "R8 done after stop period");
        tick(1'b0, 1'b0, 7'h00);
        check(done, 0, "R8 done one cycle");
        check(busy, 0, "R8 busy low after done");
        for (int k = 0; k < 3; k++) begin
            tick(1'b1, 1'b0, 7'h00);
            check(tx, 1, "R7 no extra frame after busy load");
            check(busy, 0, "R9 idle busy low");
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        // Reset state
        repeat (3) tick(1'b0, 1'b0, 7'h00);
        check(tx, 1, "R1 reset tx");
        check(busy, 1, "R1 reset busy");
        check(done, 0, "R1 reset done");
        rst_n = 1'b1;

        // Preamble with a load pulse that must be ignored
        for (int i = 0; i < 11; i++) begin
            tick(1'b1, i == 3, 7'h11);
            check(tx, 1, "R2 preamble tx high");
            check(busy, (i < 10) ? 1 : 0, "R2 preamble busy");
        end
        for (int i = 0; i < 4; i++) begin
            tick(1'b1, 1'b0, 7'h00);
            check(tx, 1, "R2 preamble load ignored tx");
            check(busy, 0, "R2 preamble load ignored busy");
        end

        // Vector table walk, bit enable every cycle
        for (int v = 0; v < 6; v++) begin
            check(model_crc(VEC[v][9:3]), VEC[v][2:0], "R4 model vs table");
            send_frame(VEC[v][9:3], VEC[v][2:0], 0);
        end

        // Directed: bit enable one cycle in three
        send_frame(7'h55, model_crc(7'h55), 2);
        send_frame(7'h33, model_crc(7'h33), 2);

        // Directed: reset in mid-frame returns to preamble
        tick(1'b1, 1'b1, 7'h7E);
        repeat (12) tick(1'b1, 1'b0, 7'h00);
        rst_n = 1'b0;
        tick(1'b1, 1'b0, 7'h00);
        check(tx, 1, "R1 mid-frame reset tx");
        check(busy, 1, "R1 mid-frame reset busy");
        check(done, 0, "R1 mid-frame reset done");
        rst_n = 1'b1;
        for (int i = 0; i < 11; i++) begin
            tick(1'b1, 1'b0, 7'h00);
            check(busy, (i < 10) ? 1 : 0, "R2 preamble after second reset");
        end
        send_frame(7'h01, 3'b011, 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule